// File: doc/BRIEF.md
# Byte-Wide Asynchronous SRAM Emulator

This block stands in for a byte-wide asynchronous static RAM inside a chip. An external controller can drive it with the usual active-low select, output-enable and write-enable strobes, an address and an 8-bit data bus. The bidirectional bus is split into a data input, a data output and a single output-enable for the pad driver. A fast sample clock takes in every pin. The block decodes the sampled pins as the device truth table does. It returns stored bytes or leaves the bus undriven, and it commits a write when the write window closes.

The write window is the span in which select and write-enable are both low. It closes when either strobe rises, and the address and data held just before the closing edge are stored. The array depth comes from the address-width parameter, so the array can be sized to fit on-chip memory. Every pin passes through a two-stage synchronizer. Pins sampled at clock edge n therefore show on the outputs after edge n+2.

Top module: `sram_emu`

## Requirements
- R1: While the synchronous active-high reset is held, `data_oe` is 0 and `data_out` is 0.
- R2: When `ce_n` is sampled high, `data_oe` is 0 after the edge two cycles later, whatever `oe_n` and `we_n` are.
- R3: When `ce_n`=0, `oe_n`=0 and `we_n`=1 are sampled at edge n, `data_oe` is 1 after edge n+2 and `data_out` holds the byte stored at the sampled address.
- R4: When `ce_n`=0 and `we_n`=0 are sampled, `data_oe` is 0 two cycles later, whatever `oe_n` is.
- R5: When `ce_n`=0 with `oe_n`=1 and `we_n`=1 are sampled, `data_oe` is 0 two cycles later.
- R6: A write window closed by `we_n` rising stores the data and address of the last sample taken inside the window.
- R7: A write window closed by `ce_n` rising, with `we_n` still low, stores the same way as R6.
- R8: When `ce_n` and `we_n` rise in the same sample, the byte is stored exactly once and `data_oe` stays 0 after the window.
- R9: Values on `data_in` or `addr` before the last in-window sample have no effect on what is stored.
- R10: A read sampled directly after a window closes, at the same address, returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, faster than the strobe activity |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Data arriving from the bus |
| data_out | output | 8 | Data to drive onto the bus |
| data_oe | output | 1 | Drive enable for the bus; 0 means high impedance |

## Verification
The bench closes write windows in three ways: with write-enable, with chip select, and with both strobes rising in the same sample. A design that keyed the store to only one strobe would lose the other windows' bytes, and a design that stored on window entry would keep stale data where the bus changes inside the window. A read is issued directly after a write to the same address. Without the write-before-read ordering, that read returns the old byte. Writes are also run with output enable held low and with select high under all strobe patterns. A decoder that let output enable win over write-enable, or that ignored select, would drive the bus when it must not.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PIN_DESEL = 2'd0,
        PIN_READ  = 2'd1,
        PIN_WRITE = 2'd2,
        PIN_QUIET = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } ctrl_pins_t;

    localparam ctrl_pins_t CTRL_IDLE = 3'b111;

    function automatic pin_mode_e decode_pins(ctrl_pins_t c);
        if (c.ce_n)       return PIN_DESEL;
        else if (!c.we_n) return PIN_WRITE;
        else if (!c.oe_n) return PIN_READ;
        else              return PIN_QUIET;
    endfunction

    function automatic logic in_window(ctrl_pins_t c);
        return !c.ce_n && !c.we_n;
    endfunction

endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_pins_t        pin_ctrl,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [DATA_W-1:0] pin_data,
    output ctrl_pins_t        s_ctrl,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_data
);
    localparam int BUS_W = $bits(ctrl_pins_t) + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] RST_VAL = {CTRL_IDLE, {(ADDR_W + DATA_W){1'b0}}};

    logic [BUS_W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= {pin_ctrl, pin_addr, pin_data};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign {s_ctrl, s_addr, s_data} = stage_q[STAGES-1];

endmodule

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_pins_t        cur_ctrl,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    ctrl_pins_t        prev_ctrl;
    logic [ADDR_W-1:0] prev_addr;
    logic [DATA_W-1:0] prev_data;
    pin_mode_e         cur_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ctrl <= CTRL_IDLE;
            prev_addr <= '0;
            prev_data <= '0;
        end else begin
            prev_ctrl <= cur_ctrl;
            prev_addr <= cur_addr;
            prev_data <= cur_data;
        end
    end

    assign cur_mode = decode_pins(cur_ctrl);
    // window closes when the last sample was inside and this one is not
    assign wr_stb   = in_window(prev_ctrl) && !in_window(cur_ctrl);
    assign wr_addr  = prev_addr;
    assign wr_data  = prev_data;
    assign rd_en    = (cur_mode == PIN_READ);
    assign rd_addr  = cur_addr;

    // a closed window needs a fresh in-window sample before it can close again
    assert_single_store_R8: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_dout,
    output logic              rd_oe
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              fwd_hit;

    always_ff @(posedge clk) begin
        if (wr_stb) mem[wr_addr] <= wr_data;
    end

    assign fwd_hit = wr_stb && (wr_addr == rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_oe   <= 1'b0;
            rd_dout <= '0;
        end else begin
            rd_oe <= rd_en;
            if (rd_en) rd_dout <= fwd_hit ? wr_data : mem[rd_addr];
        end
    end

    // same-edge write and read of one address must return the new byte
    assert_fwd_new_byte_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && rd_en && wr_addr == rd_addr) |=> (rd_dout == $past(wr_data)));

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe
);
    ctrl_pins_t        pin_ctrl;
    ctrl_pins_t        s_ctrl;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [1:0]        since_rst;

    assign pin_ctrl = {ce_n, oe_n, we_n};

    sram_emu_sync #(.ADDR_W(ADDR_W), .STAGES(2)) sync_i (
        .clk(clk), .rst(rst),
        .pin_ctrl(pin_ctrl), .pin_addr(addr), .pin_data(data_in),
        .s_ctrl(s_ctrl), .s_addr(s_addr), .s_data(s_data)
    );

    sram_emu_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst(rst),
        .cur_ctrl(s_ctrl), .cur_addr(s_addr), .cur_data(s_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr)
    );

    sram_emu_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst(rst),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_dout(data_out), .rd_oe(data_oe)
    );

    // counts cycles since reset so pin history checks look only at valid samples
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    assert_deselect_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && $past(ce_n, 3)) |-> !data_oe);

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && !$past(ce_n, 3) && !$past(oe_n, 3) && $past(we_n, 3)) |-> data_oe);

    assert_write_hiz_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && !$past(ce_n, 3) && !$past(we_n, 3)) |-> !data_oe);

    assert_quiet_hiz_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && !$past(ce_n, 3) && $past(oe_n, 3) && $past(we_n, 3)) |-> !data_oe);

endmodule

// File: tb/sram_emu_tb_top.sv
module sram_emu_tb_top;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data_in = '0;
    logic [7:0]    data_out;
    logic          data_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_emu #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    // behavioural reference: pin samples travel through a short history,
    // the store happens before the read of the same edge
    bit [7:0]  ref_mem [int];
    string     ref_tag [int];
    int        h_ce [3], h_oe [3], h_we [3], h_a [3], h_d [3];
    bit        exp_oe;
    bit [7:0]  exp_dout;
    bit        exp_known;
    string     exp_tag;
    string     wr_tag = "R6";

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                h_ce[i] = 1; h_oe[i] = 1; h_we[i] = 1; h_a[i] = 0; h_d[i] = 0;
            end
            exp_oe = 0; exp_dout = 0; exp_known = 1; exp_tag = "R1 reset";
        end else begin
            bit now_win, old_win;
            now_win = (h_ce[1] == 0) && (h_we[1] == 0);
            old_win = (h_ce[2] == 0) && (h_we[2] == 0);
            if (old_win && !now_win) begin
                ref_mem[h_a[2]] = h_d[2][7:0];
                ref_tag[h_a[2]] = wr_tag;
            end
            if (h_ce[1] == 1) begin
                exp_oe = 0; exp_tag = "R2 deselect";
            end else if (h_we[1] == 0) begin
                exp_oe = 0; exp_tag = "R4 write no drive";
            end else if (h_oe[1] == 0) begin
                exp_oe = 1;
                if (ref_mem.exists(h_a[1])) begin
                    exp_dout = ref_mem[h_a[1]]; exp_known = 1;
                    exp_tag = {"R3 read / ", ref_tag[h_a[1]]};
                end else begin
                    exp_known = 0; exp_tag = "R3 read";
                end
            end else begin
                exp_oe = 0; exp_tag = "R5 outputs off";
            end
            for (int i = 2; i > 0; i--) begin
                h_ce[i] = h_ce[i-1]; h_oe[i] = h_oe[i-1]; h_we[i] = h_we[i-1];
                h_a[i] = h_a[i-1]; h_d[i] = h_d[i-1];
            end
            h_ce[0] = ce_n; h_oe[0] = oe_n; h_we[0] = we_n;
            h_a[0] = int'(addr); h_d[0] = int'(data_in);
        end
        #2;
        if (!done) begin
            checks++;
            if (data_oe !== exp_oe) begin
                errors++;
                $display("FAIL %s: data_oe=%0b expected %0b", exp_tag, data_oe, exp_oe);
            end else if ((exp_oe || rst) && exp_known) begin
                checks++;
                if (data_out !== exp_dout) begin
                    errors++;
                    $display("FAIL %s: data_out=%02h expected %02h", exp_tag, data_out, exp_dout);
                end
            end
        end
    end

    task automatic pins(input logic c, input logic o, input logic w,
                        input int a, input int d, input int n);
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; addr = AW'(a); data_in = d[7:0];
        repeat (n - 1) @(negedge clk);
    endtask

    // R6: window closed by write enable
    task automatic write_by_we(input int a, input int d, input logic o);
        wr_tag = "R6 we-ended";
        pins(0, o, 1, a, d, 2);
        pins(0, o, 0, a, d, 3);
        pins(0, o, 1, a, d, 2);
        pins(1, 1, 1, a, d, 2);
    endtask

    // R7: window closed by chip select
    task automatic write_by_ce(input int a, input int d);
        wr_tag = "R7 ce-ended";
        pins(1, 1, 0, a, d, 2);
        pins(0, 1, 0, a, d, 3);
        pins(1, 1, 0, a, d, 2);
        pins(1, 1, 1, a, d, 2);
    endtask

    // R8: both strobes rise together, output enable low afterwards
    task automatic write_joint(input int a, input int d);
        wr_tag = "R8 joint rise";
        pins(0, 0, 0, a, d, 3);
        pins(1, 0, 1, a, d, 4);
    endtask

    task automatic read_at(input int a);
        pins(0, 0, 1, a, 8'h5A, 4);
        pins(1, 1, 1, a, 0, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        pins(1, 1, 1, 0, 0, 3);

        for (int i = 0; i < 6; i++) write_by_we(i, 8'h10 + i * 7, i[0]);
        for (int i = 0; i < 6; i++) write_by_ce(32 + i, 8'hA0 + i * 3);
        write_joint(100, 8'h3C);
        write_joint(101, 8'hC3);

        // R9: bus churns inside the window, only the final sample counts
        wr_tag = "R9 last sample";
        pins(0, 1, 0, 200, 8'h01, 2);
        pins(0, 1, 0, 201, 8'h02, 2);
        pins(0, 1, 0, 202, 8'h77, 2);
        pins(0, 1, 1, 202, 8'hEE, 3);

        // R10: read issued in the sample right after the window closes
        wr_tag = "R10 back-to-back";
        pins(0, 0, 0, 300, 8'h96, 3);
        pins(0, 0, 1, 300, 8'h00, 4);
        pins(1, 1, 1, 0, 0, 2);

        for (int i = 0; i < 6; i++) read_at(i);
        for (int i = 0; i < 6; i++) read_at(32 + i);
        read_at(100); read_at(101); read_at(202); read_at(300);
        read_at(200); read_at(201);

        // R2: deselected under every strobe pattern
        for (int p = 0; p < 4; p++) pins(1, p[0], p[1], 1, 8'hFF, 3);
        // R5: selected, outputs off
        pins(0, 1, 1, 1, 0, 4);
        // R4: write with output enable low, then readback
        write_by_we(400, 8'h4D, 1'b0);
        read_at(400);
        pins(1, 1, 1, 0, 0, 4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule